// File: doc/BRIEF.md
# MDIO Management Station Controller

This block lets a host reach the management registers of external Ethernet PHYs over a two-wire serial management interface (clock MDC, bidirectional data MDIO). The host sees two 16-bit registers. The data register holds the value to send on a write and receives the result of a read. The station register holds the target PHY address, the target register address and a direction bit. Writing the station register is the command: the block raises its busy flag on the next clock, shifts out a clause 22 management frame, and on reads collects sixteen bits from the PHY. It then stores the result in the data register and drops busy in the same cycle.

The engine is a state machine with six states. ST_IDLE waits for a command. ST_PREAMBLE sends 32 ones. ST_HEADER sends start, opcode and both addresses (14 bits). ST_TURN covers the two turnaround bits. ST_DATA moves sixteen data bits. ST_FINISH lasts one cycle and hands the result to the register block. The transitions are as follows. A command moves ST_IDLE to ST_PREAMBLE. The MDC falling edge that ends the last bit of a phase moves ST_PREAMBLE to ST_HEADER, ST_HEADER to ST_TURN, ST_TURN to ST_DATA and ST_DATA to ST_FINISH. ST_FINISH always returns to ST_IDLE.

MDC comes from the system clock through a divider with a run-time half-period input. A PHY that does not pull the line low in the second turnaround bit is treated as absent, and the read then returns all ones.

Top module: `mdio_station`

## Requirements
- R1: After reset both registers read 0, busy is 0, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: A host write with `host_addr` = 1 while not busy starts a transaction. Bit 15 of the station register reads 1 from the next cycle until the transaction ends.
- R3: While a transaction runs, MDC has a period of 2*(`mdc_half`+1) system clocks and starts low. Between transactions MDC stays low.
- R4: Every frame begins with 32 bits of 1 followed by the start pattern 0 then 1. Each bit is launched when MDC falls and is held until MDC next falls.
- R5: Station bit 10 selects the direction. A 1 means write and is sent as opcode 0,1. A 0 means read and is sent as opcode 1,0.
- R6: The PHY address is taken from station bits 4:0 and the register address from bits 9:5. Each is sent MSB first, PHY address before register address.
- R7: On a write, the block drives the whole frame, including turnaround 1,0 and then the sixteen data register bits, MSB first.
- R8: On a read, the block releases MDIO for the two turnaround bits and the sixteen data bits. It samples MDIO on each MDC rise in the data phase, MSB first. The assembled word is in the data register when busy returns to 0.
- R9: If MDIO is high at the MDC rise of the second turnaround bit of a read, the data register receives 0xFFFF.
- R10: Host writes to either register while busy are ignored. The running frame, the stored command and the data register keep their values.
- R11: A station register read returns PHY address in bits 4:0, register address in bits 9:5, direction in bit 10 and busy in bit 15. Bits 14:11 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle |
| host_addr | input | 1 | Register select: 0 data, 1 station |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read value of the selected register |
| mdc_half | input | DIV_W | MDC half period minus one, in system clocks |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the station |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
Reads are swept over all 32 PHY addresses. Each address pairs with a register address derived from it, and a bench PHY answers only on a subset of addresses. This separates the returned-data path from the all-ones path for absent PHYs and shows that the address fields are serialised in the right order. Writes are swept over all 32 register addresses with data words that differ in every nibble, which exposes bit-order and turnaround errors in the driven frame. Divider settings 0, 1 and 3 tell a correct MDC period apart from an off-by-one. A second command and a data write issued mid-frame show whether busy-time writes leak into the running transfer or into the stored registers.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PHY_W    = 5;
    localparam int REG_W    = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_LEN  = 32;
    localparam int HDR_LEN  = 2 + 2 + PHY_W + REG_W;
    localparam int TA_LEN   = 2;
    localparam int FRAME_W  = HDR_LEN + TA_LEN + DATA_W;
    localparam int CNT_W    = $clog2(PRE_LEN) + 1;

    localparam int STA_PHY_LSB  = 0;
    localparam int STA_REG_LSB  = STA_PHY_LSB + PHY_W;
    localparam int STA_OP_BIT   = STA_REG_LSB + REG_W;
    localparam int STA_BUSY_BIT = DATA_W - 1;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OPC_WR   = 2'b01;
    localparam logic [1:0] OPC_RD   = 2'b10;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_FINISH
    } mgmt_state_e;

    typedef struct packed {
        logic             is_write;
        logic [REG_W-1:0] regad;
        logic [PHY_W-1:0] phyad;
    } mgmt_cmd_t;

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             at_edge;

    assign at_edge  = run && (cnt_q == half);
    assign rise_evt = at_edge && !mdc_q;
    assign fall_evt = at_edge && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (at_edge) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mgmt_cmd_t         start_cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  mdc_half,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rd_data
);

    mgmt_state_e        state_q, state_d;
    logic [CNT_W-1:0]   bit_q;
    logic [CNT_W-1:0]   last_bit;
    logic [FRAME_W-1:0] tx_sr;
    logic [DATA_W-1:0]  rx_sr;
    logic               is_wr_q;
    logic               nophy_q;
    logic               run;
    logic               rise_evt;
    logic               fall_evt;
    logic               phase_end;

    assign run = (state_q == ST_PREAMBLE) || (state_q == ST_HEADER) ||
                 (state_q == ST_TURN)     || (state_q == ST_DATA);

    mdc_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half     (mdc_half),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: last_bit = CNT_W'(PRE_LEN - 1);
            ST_HEADER:   last_bit = CNT_W'(HDR_LEN - 1);
            ST_TURN:     last_bit = CNT_W'(TA_LEN - 1);
            ST_DATA:     last_bit = CNT_W'(DATA_W - 1);
            default:     last_bit = '0;
        endcase
    end

    assign phase_end = fall_evt && (bit_q == last_bit);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)     state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (phase_end) state_d = ST_HEADER;
            ST_HEADER:   if (phase_end) state_d = ST_TURN;
            ST_TURN:     if (phase_end) state_d = ST_DATA;
            ST_DATA:     if (phase_end) state_d = ST_FINISH;
            ST_FINISH:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            is_wr_q <= 1'b0;
            nophy_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                bit_q   <= '0;
                is_wr_q <= start_cmd.is_write;
                nophy_q <= 1'b0;
                rx_sr   <= '0;
                tx_sr   <= {SOF_BITS,
                            start_cmd.is_write ? OPC_WR : OPC_RD,
                            start_cmd.phyad,
                            start_cmd.regad,
                            TA_DRIVE,
                            start_cmd.is_write ? wr_data : {DATA_W{1'b0}}};
            end
        end else begin
            if (fall_evt) begin
                bit_q <= phase_end ? '0 : bit_q + 1'b1;
                if (state_q != ST_PREAMBLE) tx_sr <= tx_sr << 1;
            end
            if (rise_evt && !is_wr_q) begin
                if (state_q == ST_TURN && bit_q == CNT_W'(TA_LEN - 1))
                    nophy_q <= mdio_i;
                if (state_q == ST_DATA)
                    rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_PREAMBLE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HEADER: begin
                mdio_o  = tx_sr[FRAME_W-1];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                mdio_o  = tx_sr[FRAME_W-1];
                mdio_oe = is_wr_q;
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_FINISH);
    assign done_rd = done && !is_wr_q;
    assign rd_data = nophy_q ? {DATA_W{1'b1}} : rx_sr;

    // R3: clock held low outside an active frame
    p_mdc_low_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc);

    // R4: the line value only moves on a falling MDC edge
    p_launch_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fall_evt) |=> $stable(mdio_o));

    // R8: data phase of a read shifts in the pin value seen at the rise
    p_rx_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && rise_evt && !is_wr_q) |=> (rx_sr[0] == $past(mdio_i)));

    // R7: a write frame never releases the line while the clock runs
    p_write_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && is_wr_q) |-> mdio_oe);

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_rd,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output mgmt_cmd_t         start_cmd,
    output logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] data_q;
    mgmt_cmd_t         sta_q;
    logic [DATA_W-1:0] sta_view;

    assign start = host_we && host_addr && !busy;

    always_comb begin
        start_cmd.is_write = host_wdata[STA_OP_BIT];
        start_cmd.regad    = host_wdata[STA_REG_LSB +: REG_W];
        start_cmd.phyad    = host_wdata[STA_PHY_LSB +: PHY_W];
    end

    assign wr_data = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            sta_q  <= '0;
        end else begin
            if (start) sta_q <= start_cmd;
            if (done_rd)
                data_q <= rd_data;
            else if (host_we && !host_addr && !busy)
                data_q <= host_wdata;
        end
    end

    always_comb begin
        sta_view                            = '0;
        sta_view[STA_PHY_LSB +: PHY_W]      = sta_q.phyad;
        sta_view[STA_REG_LSB +: REG_W]      = sta_q.regad;
        sta_view[STA_OP_BIT]                = sta_q.is_write;
        sta_view[STA_BUSY_BIT]              = busy;
        host_rdata = host_addr ? sta_view : data_q;
    end

    // R2: a command is visible as busy on the following cycle
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R10: commands issued during a transfer leave the stored command alone
    p_ignore_station_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we) |=> $stable(sta_q));

    // R10: data writes during a transfer are dropped unless a read result lands
    p_ignore_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_rd) |=> $stable(data_q));

    // R8: the read result is what the engine presented at completion
    p_read_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_rd |=> (data_q == $past(rd_data)));

endmodule

// File: rtl/mdio_station.sv
module mdio_station
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DIV_W-1:0]  mdc_half,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic              start;
    mgmt_cmd_t         start_cmd;
    logic [DATA_W-1:0] wr_data;
    logic              busy;
    logic              done;
    logic              done_rd;
    logic [DATA_W-1:0] rd_data;

    mdio_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done),
        .done_rd    (done_rd),
        .rd_data    (rd_data),
        .start      (start),
        .start_cmd  (start_cmd),
        .wr_data    (wr_data)
    );

    mdio_frame_engine #(.DIV_W(DIV_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_cmd (start_cmd),
        .wr_data   (wr_data),
        .mdc_half  (mdc_half),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .done_rd   (done_rd),
        .rd_data   (rd_data)
    );

    // R1: the line is released whenever no transfer is running
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

endmodule

// File: tb/mdio_station_bench.sv
`timescale 1ns/1ps
module mdio_station_bench;

    localparam int DIV_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [DIV_W-1:0] mdc_half = '0;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    always #2 clk = !clk;

    // bench PHY state (written only by the monitor block)
    logic        phy_drv = 1'b0;
    logic        phy_val = 1'b1;
    logic [0:63] cap_bits = '0;
    logic [0:63] cap_oe = '0;
    int          bitidx = 0;
    int          cyc = 0;
    int          last_rise = 0;
    int          last_period = 0;
    int          mon_checks = 0;
    int          mon_fails = 0;
    logic        mdc_prev = 1'b0;

    int checks = 0;
    int fails = 0;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_station #(.DIV_W(DIV_W)) u_mdio_station (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mdc_half   (mdc_half),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i)
    );

    function automatic logic phy_present(input logic [4:0] p);
        return (int'(p) % 3) == 1;
    endfunction

    function automatic logic [15:0] phy_value(input logic [4:0] p, input logic [4:0] r);
        logic [5:0] low;
        low = 6'((int'(p) * 3 + int'(r)) & 63);
        return {p, r, low};
    endfunction

    // bench PHY and line monitor, sampling away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && host_we && host_addr && !host_rdata[15]) begin
            bitidx   = 0;
            cap_bits = '0;
            cap_oe   = '0;
            phy_drv  = 1'b0;
        end else begin
            if (mdc && !mdc_prev) begin
                if (bitidx < 64) begin
                    cap_bits[bitidx] = mdio_i;
                    cap_oe[bitidx]   = mdio_oe;
                end
                mon_checks = mon_checks + 1;
                if (mdio_oe && phy_drv) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R8: line contention at bit %0d actual oe=%0d expected oe=0",
                             bitidx, mdio_oe);
                end
                bitidx      = bitidx + 1;
                last_period = cyc - last_rise;
                last_rise   = cyc;
            end
            if (!mdc && mdc_prev) begin
                phy_drv = 1'b0;
                if (cap_bits[34] && !cap_bits[35] && phy_present(cap_bits[36:40]) &&
                    bitidx >= 47 && bitidx <= 63) begin
                    phy_drv = 1'b1;
                    if (bitidx == 47) phy_val = 1'b0;
                    else phy_val = phy_value(cap_bits[36:40], cap_bits[41:45])[63 - bitidx];
                end
            end
        end
        mdc_prev = mdc;
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [15:0] d, input logic check_busy);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (check_busy) chk(host_rdata[15] == 1'b1, "R2 busy after start",
                            64'(host_rdata[15]), 64'd1);
    endtask

    task automatic wait_idle();
        int n;
        host_addr = 1'b1;
        n = 0;
        @(negedge clk);
        while (host_rdata[15] && n < 20000) begin
            @(negedge clk);
            n = n + 1;
        end
        chk(n < 20000, "R2 busy clears", 64'(n), 64'd0);
    endtask

    task automatic run_xact(input int half, input logic wr, input logic [4:0] p,
                            input logic [4:0] r, input logic [15:0] d);
        logic [0:63] exp;
        logic [15:0] got;
        logic [15:0] want;
        mdc_half = DIV_W'(half);
        if (wr) host_write(1'b0, d, 1'b0);
        host_write(1'b1, {5'b0, wr, r, p}, 1'b1);
        wait_idle();
        exp = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, p, r,
               wr ? 2'b10 : 2'b00, wr ? d : 16'h0};
        chk(cap_bits[0:33] == exp[0:33], "R4 preamble and start",
            64'(cap_bits[0:33]), 64'(exp[0:33]));
        chk(cap_bits[34:35] == exp[34:35], "R5 opcode",
            64'(cap_bits[34:35]), 64'(exp[34:35]));
        chk(cap_bits[36:45] == exp[36:45], "R6 addresses",
            64'(cap_bits[36:45]), 64'(exp[36:45]));
        chk(last_period == 2 * (half + 1), "R3 mdc period",
            64'(last_period), 64'(2 * (half + 1)));
        chk(mdc == 1'b0, "R3 mdc low after frame", 64'(mdc), 64'd0);
        chk(host_rdata == {5'b0, wr, r, p}, "R11 station readback",
            64'(host_rdata), 64'({5'b0, wr, r, p}));
        if (wr) begin
            chk(cap_bits[46:63] == exp[46:63], "R7 turnaround and data",
                64'(cap_bits[46:63]), 64'(exp[46:63]));
            chk(cap_oe == '1, "R7 driven frame", 64'(cap_oe), 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
            chk(cap_oe[0:45] == '1 && cap_oe[46:63] == '0, "R8 line released",
                64'(cap_oe), 64'hFFFF_FFFF_FFFC_0000);
            host_addr = 1'b0;
            #1;
            got  = host_rdata;
            want = phy_present(p) ? phy_value(p, r) : 16'hFFFF;
            if (phy_present(p)) chk(got == want, "R8 read data", 64'(got), 64'(want));
            else                chk(got == want, "R9 absent phy ones", 64'(got), 64'(want));
        end
    endtask

    initial begin
        #(4 * 200000);
        $display("FAIL watchdog: run did not finish (R2) actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        host_addr = 1'b0;
        #1;
        chk(host_rdata == 16'h0, "R1 data reset", 64'(host_rdata), 64'd0);
        host_addr = 1'b1;
        #1;
        chk(host_rdata == 16'h0, "R1 station reset", 64'(host_rdata), 64'd0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle",
            64'({mdc, mdio_oe}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle after release",
            64'({mdc, mdio_oe}), 64'd0);

        // divider settings
        run_xact(0, 1'b1, 5'd1, 5'd2, 16'h9C35);
        run_xact(1, 1'b1, 5'd17, 5'd30, 16'h5AC3);
        run_xact(3, 1'b0, 5'd4, 5'd11, 16'h0);

        // read sweep over every PHY address
        for (int p = 0; p < 32; p++) begin
            run_xact(0, 1'b0, 5'(p), 5'(p ^ 21), 16'h0);
        end

        // write sweep over every register address
        for (int r = 0; r < 32; r++) begin
            run_xact(0, 1'b1, 5'd4, 5'(r), 16'(16'h1357 ^ (r * 16'h1111)));
        end

        // R10: commands and data writes during a transfer
        mdc_half = DIV_W'(2);
        host_write(1'b0, 16'hA5A5, 1'b0);
        host_write(1'b1, {5'b0, 1'b1, 5'd9, 5'd6}, 1'b1);
        repeat (40) @(negedge clk);
        host_write(1'b1, {5'b0, 1'b0, 5'd3, 5'd12}, 1'b0);
        host_write(1'b0, 16'h1234, 1'b0);
        wait_idle();
        chk(host_rdata == {5'b0, 1'b1, 5'd9, 5'd6}, "R10 station kept",
            64'(host_rdata), 64'({5'b0, 1'b1, 5'd9, 5'd6}));
        chk(cap_bits[36:40] == 5'd6 && cap_bits[48:63] == 16'hA5A5, "R10 frame kept",
            64'({cap_bits[36:40], cap_bits[48:63]}), 64'({5'd6, 16'hA5A5}));
        host_addr = 1'b0;
        #1;
        chk(host_rdata == 16'hA5A5, "R10 data kept", 64'(host_rdata), 64'hA5A5);
        repeat (30) @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 no second frame",
            64'({mdc, mdio_oe}), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule